// File: doc/BRIEF.md
# Global Access Checker

This block judges every access that a CPU or a debug port makes into a 23-bit global address space. Each request carries an address, a read/write flag, a byte/word flag, the requester, a firmware-command flag and the operating mode. The block matches the address against four on-chip windows: registers, RAM, EEPROM and Flash. Each window's size and top address are parameters. The block then returns one verdict: internal access, external bus access, ignored access with undefined read data, or illegal-access reset.

For a word access the block also supplies the address of the second byte. The second byte always stays inside the 64 KB page of the first, so a word that starts at a page's last byte continues at that page's first byte. When the verdict is a reset, the block raises a one-cycle reset pulse, which goes to the system reset logic.

Requests enter on a valid/ready channel and verdicts leave on a second valid/ready channel, through a single register stage. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or its contents are being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds still and no new request enters. The reset pulse is a plain control output and is not held back by the response channel.

Top module: `gaccess_checker`

## Requirements
- R1: Window map (default parameters): registers span 0x000000–0x0007FF, RAM ends at 0x0FFFFF, EEPROM ends at 0x13FFFF and Flash ends at 0x7FFFFF, each window reaching down by its size (32 KB, 4 KB and 512 KB). `rsp_outcome` is encoded 0 = internal, 1 = external, 2 = ignored, 3 = reset. Any access that hits a window gets outcome 0, except in the cases covered by R5, R6 and R7.
- R2: Mode codes are 0 = normal single-chip, 1 = special single-chip, 2 = emulation single-chip and 3 = expanded. In mode 3, an address outside every window gets outcome 1 with `rsp_undef` = 0, and the reset pulse never fires.
- R3: Outside the windows, the range 0x140000–0x1FFFFF is unimplemented and every other address is external space. In mode 2:
  - Any access to the unimplemented range gets outcome 1.
  - A CPU access to external space gets outcome 3, even when it is a firmware command.
  - A debug access to external space gets outcome 1 with `rsp_undef` = 1.
- R4: In modes 0 and 1, an access outside every window is resolved as follows:
  - A CPU access that is not a firmware command gets outcome 3.
  - A CPU firmware command gets outcome 2.
  - A debug access gets outcome 2.
  - Outcome 2 always comes with `rsp_undef` = 1.
- R5: A CPU word that starts at the top byte of the register or EEPROM window behaves as follows:
  - In mode 3 it gets outcome 0.
  - In modes 0–2 it gets outcome 3, unless it is a firmware command, in which case it gets 0.
  - A CPU word at the Flash top byte gets outcome 0 in every mode.
- R6: A CPU word that starts at the RAM top byte gets outcome 2 with `rsp_undef` = 1 in mode 3. In modes 0–2 it gets outcome 3, unless it is a firmware command, in which case it gets outcome 2.
- R7: A debug word request with address bit 0 set is blocked. It gets outcome 2 with `rsp_undef` = 1 and never a reset, whatever the mode and region.
- R8: For a word, `rsp_addr2` keeps bits 22:16 of the address and adds one to bits 15:0 modulo 65536. This makes 0x2AFFFF continue at 0x2A0000. For a byte, `rsp_addr2` equals `rsp_addr`.
- R9: `illegal_rst` is high for exactly the one cycle after a request with outcome 3 is taken. In that same cycle `rsp_valid` is 1 and `rsp_outcome` is 3. In every other cycle `illegal_rst` is low.
- R10: After reset, `rsp_valid` and `illegal_rst` are 0 and `req_ready` is 1. `rsp_valid` rises in the cycle after a request is taken. While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds stable and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 23 | Global byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_debug | input | 1 | 1 = debug port, 0 = CPU |
| req_fwcmd | input | 1 | CPU firmware-command access |
| req_mode | input | 2 | Operating mode code (R2) |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Verdict taken |
| rsp_outcome | output | 2 | Verdict code (R1) |
| rsp_undef | output | 1 | Read data will be undefined |
| rsp_addr | output | 23 | First byte address |
| rsp_addr2 | output | 23 | Second byte address (page-wrapped) |
| rsp_word | output | 1 | Copy of the size flag |
| rsp_write | output | 1 | Copy of the direction flag |
| illegal_rst | output | 1 | One-cycle illegal-access reset pulse |

## Verification
The assertions check several properties on every cycle:
- Each reset pulse lines up with a taken request and a response showing outcome 3.
- A response stalled by back-pressure does not change.
- A blocked debug word never resets.
- Expanded mode never resets.
- A word at a page's last byte wraps its second address.
- An ignored verdict always flags undefined data.

The verdict for each mode, requester, region and top-byte case can only be shown by the bench's directed scenarios. Each scenario sends a request chosen for that case and compares the outcome against the value given in R1–R6. The same applies to the firmware-command exemptions and the Flash exception.

// File: rtl/gac_pkg.sv
package gac_pkg;

  typedef enum logic [1:0] {
    MD_NSC = 2'd0,
    MD_SSC = 2'd1,
    MD_ESC = 2'd2,
    MD_EXP = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OC_INT = 2'd0,
    OC_EXT = 2'd1,
    OC_IGN = 2'd2,
    OC_RST = 2'd3
  } outcome_e;

  // Window indices 0..3 match the on-chip windows in the decoder.
  typedef enum logic [2:0] {
    RG_REG   = 3'd0,
    RG_RAM   = 3'd1,
    RG_EE    = 3'd2,
    RG_FLASH = 3'd3,
    RG_EXT   = 3'd4,
    RG_GAP   = 3'd5
  } region_e;

  typedef struct packed {
    region_e region;
    logic    at_top;
  } decode_t;

  typedef struct packed {
    outcome_e oc;
    logic     undef;
  } verdict_t;

endpackage

// File: rtl/gac_region_decode.sv
module gac_region_decode
  import gac_pkg::*;
#(
  parameter int unsigned AW          = 23,
  parameter int unsigned REG_BYTES   = 2048,
  parameter int unsigned RAM_BYTES   = 32768,
  parameter int unsigned RAM_TOP     = 32'h0F_FFFF,
  parameter int unsigned EE_BYTES    = 4096,
  parameter int unsigned EE_TOP      = 32'h13_FFFF,
  parameter int unsigned FLASH_BYTES = 524288,
  parameter int unsigned FLASH_TOP   = 32'h7F_FFFF,
  parameter int unsigned LOW_EXT_TOP = 32'h13_FFFF,
  parameter int unsigned GAP_TOP     = 32'h1F_FFFF
) (
  input  logic [AW-1:0] addr,
  output decode_t       dec
);

  localparam int unsigned NWIN = 4;

  localparam logic [AW-1:0] WIN_LO [NWIN] = '{
    AW'(0),
    AW'(RAM_TOP - RAM_BYTES + 1),
    AW'(EE_TOP - EE_BYTES + 1),
    AW'(FLASH_TOP - FLASH_BYTES + 1)
  };

  localparam logic [AW-1:0] WIN_SZ [NWIN] = '{
    AW'(REG_BYTES), AW'(RAM_BYTES), AW'(EE_BYTES), AW'(FLASH_BYTES)
  };

  logic [NWIN-1:0] hit;
  logic [NWIN-1:0] top;

  // Offset-and-compare per window: one subtractor and one comparator each.
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [AW-1:0] off;
    assign off    = addr - WIN_LO[i];
    assign hit[i] = off < WIN_SZ[i];
    assign top[i] = off == (WIN_SZ[i] - AW'(1));
  end

  always_comb begin
    if (addr <= AW'(LOW_EXT_TOP))  dec.region = RG_EXT;
    else if (addr <= AW'(GAP_TOP)) dec.region = RG_GAP;
    else                           dec.region = RG_EXT;
    dec.at_top = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (hit[i]) begin
        dec.region = region_e'(3'(i));
        dec.at_top = top[i];
      end
    end
  end

endmodule

// File: rtl/gac_policy.sv
module gac_policy
  import gac_pkg::*;
(
  input  decode_t  dec,
  input  logic     word,
  input  logic     addr_lsb,
  input  logic     debug,
  input  logic     fwcmd,
  input  mode_e    mode,
  output verdict_t verdict
);

  logic single_chip;
  logic on_chip;
  logic strict;

  assign single_chip = (mode != MD_EXP);
  assign on_chip     = (dec.region != RG_EXT) && (dec.region != RG_GAP);
  assign strict      = single_chip && !fwcmd;

  always_comb begin
    verdict = '{oc: OC_INT, undef: 1'b0};
    if (debug && word && addr_lsb) begin
      // Debug port must not issue odd words: block it.
      verdict = '{oc: OC_IGN, undef: 1'b1};
    end else if (on_chip) begin
      if (!debug && word && dec.at_top) begin
        case (dec.region)
          RG_RAM:   verdict = strict ? '{oc: OC_RST, undef: 1'b0}
                                     : '{oc: OC_IGN, undef: 1'b1};
          RG_FLASH: verdict = '{oc: OC_INT, undef: 1'b0};
          default:  verdict = strict ? '{oc: OC_RST, undef: 1'b0}
                                     : '{oc: OC_INT, undef: 1'b0};
        endcase
      end
    end else begin
      case (mode)
        MD_EXP: verdict = '{oc: OC_EXT, undef: 1'b0};
        MD_ESC: begin
          if (dec.region == RG_GAP) verdict = '{oc: OC_EXT, undef: 1'b0};
          else if (debug)           verdict = '{oc: OC_EXT, undef: 1'b1};
          else                      verdict = '{oc: OC_RST, undef: 1'b0};
        end
        default: begin
          if (debug || fwcmd) verdict = '{oc: OC_IGN, undef: 1'b1};
          else                verdict = '{oc: OC_RST, undef: 1'b0};
        end
      endcase
    end
  end

endmodule

// File: rtl/gac_page_wrap.sv
module gac_page_wrap #(
  parameter int unsigned AW        = 23,
  parameter int unsigned PAGE_BITS = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          word,
  output logic [AW-1:0] addr2
);

  logic [PAGE_BITS-1:0] low_next;

  // Carry out of the page offset is dropped, so the page never changes.
  assign low_next = addr[PAGE_BITS-1:0] + PAGE_BITS'(word);
  assign addr2    = {addr[AW-1:PAGE_BITS], low_next};

endmodule

// File: rtl/gaccess_checker.sv
module gaccess_checker
  import gac_pkg::*;
#(
  parameter int unsigned AW          = 23,
  parameter int unsigned PAGE_BITS   = 16,
  parameter int unsigned REG_BYTES   = 2048,
  parameter int unsigned RAM_BYTES   = 32768,
  parameter int unsigned RAM_TOP     = 32'h0F_FFFF,
  parameter int unsigned EE_BYTES    = 4096,
  parameter int unsigned EE_TOP      = 32'h13_FFFF,
  parameter int unsigned FLASH_BYTES = 524288,
  parameter int unsigned FLASH_TOP   = 32'h7F_FFFF,
  parameter int unsigned LOW_EXT_TOP = 32'h13_FFFF,
  parameter int unsigned GAP_TOP     = 32'h1F_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_debug,
  input  logic          req_fwcmd,
  input  logic [1:0]    req_mode,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_outcome,
  output logic          rsp_undef,
  output logic [AW-1:0] rsp_addr,
  output logic [AW-1:0] rsp_addr2,
  output logic          rsp_word,
  output logic          rsp_write,
  output logic          illegal_rst
);

  decode_t       dec;
  verdict_t      verdict;
  logic [AW-1:0] addr2;
  logic          accept;

  gac_region_decode #(
    .AW(AW), .REG_BYTES(REG_BYTES),
    .RAM_BYTES(RAM_BYTES), .RAM_TOP(RAM_TOP),
    .EE_BYTES(EE_BYTES), .EE_TOP(EE_TOP),
    .FLASH_BYTES(FLASH_BYTES), .FLASH_TOP(FLASH_TOP),
    .LOW_EXT_TOP(LOW_EXT_TOP), .GAP_TOP(GAP_TOP)
  ) u_decode (
    .addr (req_addr),
    .dec  (dec)
  );

  gac_policy u_policy (
    .dec      (dec),
    .word     (req_word),
    .addr_lsb (req_addr[0]),
    .debug    (req_debug),
    .fwcmd    (req_fwcmd),
    .mode     (mode_e'(req_mode)),
    .verdict  (verdict)
  );

  gac_page_wrap #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_wrap (
    .addr  (req_addr),
    .word  (req_word),
    .addr2 (addr2)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      illegal_rst <= 1'b0;
    end else begin
      illegal_rst <= accept && (verdict.oc == OC_RST);
      if (accept)         rsp_valid <= 1'b1;
      else if (rsp_ready) rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_outcome <= 2'd0;
      rsp_undef   <= 1'b0;
      rsp_addr    <= '0;
      rsp_addr2   <= '0;
      rsp_word    <= 1'b0;
      rsp_write   <= 1'b0;
    end else if (accept) begin
      rsp_outcome <= verdict.oc;
      rsp_undef   <= verdict.undef;
      rsp_addr    <= req_addr;
      rsp_addr2   <= addr2;
      rsp_word    <= req_word;
      rsp_write   <= req_write;
    end
  end

endmodule

// File: rtl/gac_checker_sva.sv
module gac_checker_sva #(
  parameter int unsigned AW        = 23,
  parameter int unsigned PAGE_BITS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_word,
  input logic          req_debug,
  input logic [1:0]    req_mode,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_outcome,
  input logic          rsp_undef,
  input logic [AW-1:0] rsp_addr,
  input logic [AW-1:0] rsp_addr2,
  input logic          rsp_word,
  input logic          illegal_rst
);

  // R9
  rst_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rst |-> $past(req_valid && req_ready));

  // R9
  rst_with_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rst |-> (rsp_valid && rsp_outcome == 2'd3));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_outcome)
      && $stable(rsp_addr) && $stable(rsp_addr2) && $stable(rsp_undef)));

  // R10
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R7
  dbg_odd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_debug && req_word && req_addr[0])
      |=> (rsp_outcome == 2'd2 && rsp_undef && !illegal_rst));

  // R2
  expanded_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 2'd3) |=> !illegal_rst);

  // R8
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_word && (&rsp_addr[PAGE_BITS-1:0]))
      |-> (rsp_addr2[PAGE_BITS-1:0] == '0
           && rsp_addr2[AW-1:PAGE_BITS] == rsp_addr[AW-1:PAGE_BITS]));

  // R4
  ignored_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_outcome == 2'd2) |-> rsp_undef);

endmodule

bind gaccess_checker gac_checker_sva #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_word    (req_word),
  .req_debug   (req_debug),
  .req_mode    (req_mode),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_outcome (rsp_outcome),
  .rsp_undef   (rsp_undef),
  .rsp_addr    (rsp_addr),
  .rsp_addr2   (rsp_addr2),
  .rsp_word    (rsp_word),
  .illegal_rst (illegal_rst)
);

// File: tb/gaccess_checker_test.sv
module gaccess_checker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic        req_debug = 1'b0;
  logic        req_fwcmd = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_outcome;
  logic        rsp_undef;
  logic [22:0] rsp_addr;
  logic [22:0] rsp_addr2;
  logic        rsp_word;
  logic        rsp_write;
  logic        illegal_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [22:0] last_addr2;

  always #2 clk = ~clk;

  gaccess_checker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_word(req_word),
    .req_debug(req_debug), .req_fwcmd(req_fwcmd), .req_mode(req_mode),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_outcome(rsp_outcome), .rsp_undef(rsp_undef),
    .rsp_addr(rsp_addr), .rsp_addr2(rsp_addr2),
    .rsp_word(rsp_word), .rsp_write(rsp_write),
    .illegal_rst(illegal_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One request, response taken at once; checks verdict, undef flag and pulse.
  task automatic issue(input string req, input logic [22:0] addr, input logic word,
                       input logic dbg, input logic fw, input logic [1:0] mode,
                       input logic [1:0] exp_oc, input logic exp_undef, input logic exp_rst);
    @(negedge clk);
    rsp_ready = 1'b1;
    req_addr  = addr;
    req_word  = word;
    req_debug = dbg;
    req_fwcmd = fw;
    req_mode  = mode;
    req_write = ~req_write;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " outcome"}, 32'(rsp_outcome), 32'(exp_oc));
    check({req, " undef"}, 32'(rsp_undef), 32'(exp_undef));
    check({req, " R9 pulse"}, 32'(illegal_rst), 32'(exp_rst));
    last_addr2 = rsp_addr2;
    @(posedge clk);
    #1;
    if (exp_rst) check({req, " R9 pulse width"}, 32'(illegal_rst), 32'd0);
  endtask

  task automatic t_reset();
    #1;
    check("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R10 reset illegal_rst", 32'(illegal_rst), 32'd0);
    check("R10 reset req_ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_internal();
    issue("R1 ram byte nsc", 23'h0F_9000, 0, 0, 0, 2'd0, 2'd0, 0, 0);
    issue("R1 flash dbg word exp", 23'h78_0010, 1, 1, 0, 2'd3, 2'd0, 0, 0);
    issue("R1 reg word esc", 23'h00_0100, 1, 0, 0, 2'd2, 2'd0, 0, 0);
    issue("R1 ee byte top ssc", 23'h13_FFFF, 0, 0, 0, 2'd1, 2'd0, 0, 0);
  endtask

  task automatic t_expanded();
    issue("R2 high ext", 23'h30_0000, 0, 0, 0, 2'd3, 2'd1, 0, 0);
    issue("R2 gap", 23'h15_0000, 0, 0, 0, 2'd3, 2'd1, 0, 0);
    issue("R2 low ext", 23'h05_0000, 1, 0, 0, 2'd3, 2'd1, 0, 0);
  endtask

  task automatic t_emulation();
    issue("R3 gap cpu", 23'h15_0000, 0, 0, 0, 2'd2, 2'd1, 0, 0);
    issue("R3 ext cpu", 23'h25_0000, 0, 0, 0, 2'd2, 2'd3, 0, 1);
    issue("R3 ext cpu fw", 23'h25_0000, 0, 0, 1, 2'd2, 2'd3, 0, 1);
    issue("R3 ext dbg", 23'h25_0000, 0, 1, 0, 2'd2, 2'd1, 1, 0);
  endtask

  task automatic t_single();
    issue("R4 nsc cpu", 23'h05_0000, 0, 0, 0, 2'd0, 2'd3, 0, 1);
    issue("R4 ssc cpu gap", 23'h15_0000, 0, 0, 0, 2'd1, 2'd3, 0, 1);
    issue("R4 ssc fw", 23'h05_0000, 0, 0, 1, 2'd1, 2'd2, 1, 0);
    issue("R4 nsc dbg", 23'h30_0000, 0, 1, 0, 2'd0, 2'd2, 1, 0);
  endtask

  task automatic t_top_other();
    issue("R5 reg top exp", 23'h00_07FF, 1, 0, 0, 2'd3, 2'd0, 0, 0);
    issue("R5 reg top nsc", 23'h00_07FF, 1, 0, 0, 2'd0, 2'd3, 0, 1);
    issue("R5 reg top ssc fw", 23'h00_07FF, 1, 0, 1, 2'd1, 2'd0, 0, 0);
    issue("R5 ee top esc", 23'h13_FFFF, 1, 0, 0, 2'd2, 2'd3, 0, 1);
    issue("R5 flash top nsc", 23'h7F_FFFF, 1, 0, 0, 2'd0, 2'd0, 0, 0);
  endtask

  task automatic t_top_ram();
    issue("R6 ram top exp", 23'h0F_FFFF, 1, 0, 0, 2'd3, 2'd2, 1, 0);
    issue("R6 ram top nsc", 23'h0F_FFFF, 1, 0, 0, 2'd0, 2'd3, 0, 1);
    issue("R6 ram top nsc fw", 23'h0F_FFFF, 1, 0, 1, 2'd0, 2'd2, 1, 0);
  endtask

  task automatic t_debug_odd();
    issue("R7 dbg odd ram", 23'h0F_9001, 1, 1, 0, 2'd0, 2'd2, 1, 0);
    issue("R7 dbg odd flash top", 23'h7F_FFFF, 1, 1, 0, 2'd0, 2'd2, 1, 0);
    issue("R7 dbg odd ext esc", 23'h25_0001, 1, 1, 0, 2'd2, 2'd2, 1, 0);
  endtask

  task automatic t_wrap();
    issue("R8 page end", 23'h2A_FFFF, 1, 0, 0, 2'd3, 2'd1, 0, 0);
    check("R8 page end addr2", 32'(last_addr2), 32'h2A_0000);
    issue("R8 even word", 23'h30_0004, 1, 0, 0, 2'd3, 2'd1, 0, 0);
    check("R8 even word addr2", 32'(last_addr2), 32'h30_0005);
    issue("R8 byte", 23'h30_0004, 0, 0, 0, 2'd3, 2'd1, 0, 0);
    check("R8 byte addr2", 32'(last_addr2), 32'h30_0004);
    issue("R8 ram top", 23'h0F_FFFF, 1, 0, 0, 2'd3, 2'd2, 1, 0);
    check("R8 ram top addr2", 32'(last_addr2), 32'h0F_0000);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr  = 23'h25_0000;
    req_word  = 1'b0;
    req_debug = 1'b0;
    req_fwcmd = 1'b0;
    req_mode  = 2'd2;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R10 stall first valid", 32'(rsp_valid), 32'd1);
    check("R10 stall first outcome", 32'(rsp_outcome), 32'd3);
    check("R9 stall pulse", 32'(illegal_rst), 32'd1);
    check("R10 stall ready low", 32'(req_ready), 32'd0);
    req_addr = 23'h30_0000;
    req_mode = 2'd3;
    @(posedge clk);
    #1;
    check("R10 stall held outcome", 32'(rsp_outcome), 32'd3);
    check("R10 stall held addr", 32'(rsp_addr), 32'h25_0000);
    check("R9 stall no repeat", 32'(illegal_rst), 32'd0);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check("R10 second outcome", 32'(rsp_outcome), 32'd1);
    check("R10 second addr", 32'(rsp_addr), 32'h30_0000);
    check("R9 second no pulse", 32'(illegal_rst), 32'd0);
    @(posedge clk);
    #1;
    check("R10 drained", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_internal();
    t_expanded();
    t_emulation();
    t_single();
    t_top_other();
    t_top_ram();
    t_debug_odd();
    t_wrap();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule